// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Refresh

This block supervises software by counting ticks of a slow prescaled clock. Software keeps it alive by writing a two-word key to a refresh register. A refresh only counts if the second word follows the first within a short deadline of bus cycles. In windowed mode, the count must also have reached a programmable lower bound when the refresh completes. A refresh that comes too early, a wrong key word, a late second word, or a count that reaches the programmed timeout all count as a fault.

The fault path has two variants. With interrupt-first mode off, a fault raises the system-reset output at once. With it on, the interrupt output rises first and the system reset follows a fixed number of bus cycles later. Both outputs stay high until the block itself is reset. All registers are written through a narrow 16-bit write port. The 32-bit window bound and timeout value are each written as two halves. Software must keep the window bound below the timeout value.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset, `irq` and `sys_rst` are low, `refresh_word` reads 0xB480, and the window bound is 0x0000_0010.
- R2: A write to the port decodes `wr_addr` as follows: 0 = control, 1 = window upper 16 bits, 2 = window lower 16 bits, 3 = timeout upper 16 bits, 4 = timeout lower 16 bits, 5 = refresh. Both halves together form each 32-bit value.
- R3: While enabled, the counter advances by one per bus cycle in which `tick` is high. A fault is raised once the counter equals or exceeds the 32-bit timeout value.
- R4: With windowed mode on (control bit 1), a key sequence that completes while the counter is below the window bound is a fault. With windowed mode off, any count is accepted.
- R5: A valid refresh is 0xA602 written to the refresh address, followed by 0xB480. Any other word written where a key is expected is a fault.
- R6: The second key is accepted if it is written at most 20 bus cycles after the first. If it has not arrived by then, a fault is raised.
- R7: A valid refresh clears the counter to zero.
- R8: With interrupt-first mode on (control bit 2), a fault raises `irq`, and `sys_rst` rises exactly 128 bus cycles later.
- R9: With interrupt-first mode off, a fault raises `sys_rst` and `irq` stays low.
- R10: Once high, `irq` and `sys_rst` stay high until `rst`.
- R11: While the enable bit (control bit 0, set at reset) is clear, the counter holds and no fault reaches the outputs.
- R12: `refresh_word` shows the last word written to the refresh address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| tick | input | 1 | Prescaled watchdog tick, one bus cycle wide |
| irq | output | 1 | Interrupt raised ahead of reset |
| sys_rst | output | 1 | System reset request |
| refresh_word | output | 16 | Last word written to the refresh register |

## Verification
The hardest situations to reach are the exact edges of the two timing windows: a second key written on the last allowed bus cycle versus one cycle later, and a refresh that completes with the counter one tick below the window bound versus exactly on it. The bench reaches these by sweeping two quantities per run from a fresh reset. It sweeps the gap between the key writes from 1 to 22 cycles, and it sweeps the number of ticks delivered before the refresh across the whole range below the timeout. After each accepted refresh it checks that the counter was cleared: it delivers one tick short of the timeout and expects no fault, then one more tick and expects a fault.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam int HALF_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_WIN_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIN_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TMO_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TMO_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_REFRESH = 3'd5;

  typedef struct packed {
    logic irq_first;
    logic windowed;
    logic enable;
  } ctrl_t;

  typedef enum logic { KEY_IDLE, KEY_ARMED } key_state_t;

  typedef enum logic [1:0] { FLT_RUN, FLT_WAIT, FLT_HALT } fault_state_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter logic [2:0]  CTRL_INIT  = 3'b001,
  parameter logic [31:0] WIN_INIT   = 32'h0000_0010,
  parameter logic [31:0] TMO_INIT   = 32'h0004_C4B4,
  parameter logic [15:0] WORD_INIT  = 16'hB480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  win_val,
  output logic [CNT_W-1:0]  tmo_val,
  output logic [HALF_W-1:0] refresh_word,
  output logic              key_wr,
  output logic [HALF_W-1:0] key_data
);
  localparam int HI_W = CNT_W - HALF_W;

  logic [HI_W-1:0]   win_hi, tmo_hi;
  logic [HALF_W-1:0] win_lo, tmo_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl         <= ctrl_t'(CTRL_INIT);
      win_hi       <= WIN_INIT[CNT_W-1:HALF_W];
      win_lo       <= WIN_INIT[HALF_W-1:0];
      tmo_hi       <= TMO_INIT[CNT_W-1:HALF_W];
      tmo_lo       <= TMO_INIT[HALF_W-1:0];
      refresh_word <= WORD_INIT;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:    ctrl         <= ctrl_t'(wr_data[2:0]);
        A_WIN_HI:  win_hi       <= wr_data[HI_W-1:0];
        A_WIN_LO:  win_lo       <= wr_data;
        A_TMO_HI:  tmo_hi       <= wr_data[HI_W-1:0];
        A_TMO_LO:  tmo_lo       <= wr_data;
        A_REFRESH: refresh_word <= wr_data;
        default: ;
      endcase
    end
  end

  assign win_val  = {win_hi, win_lo};
  assign tmo_val  = {tmo_hi, tmo_lo};
  assign key_wr   = wr_en && (wr_addr == A_REFRESH);
  assign key_data = wr_data;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             windowed,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] win_val,
  input  logic [CNT_W-1:0] tmo_val,
  output logic             in_window,
  output logic             timeout
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (enable && tick && (count != {CNT_W{1'b1}}))
      count <= count + 1'b1;
  end

  assign in_window = !windowed || (count >= win_val);
  assign timeout   = enable && (count >= tmo_val);
endmodule

// File: rtl/wdog_key_check.sv
module wdog_key_check
  import wdog_pkg::*;
#(
  parameter int          KEY_W    = 16,
  parameter logic [15:0] KEY_A    = 16'hA602,
  parameter logic [15:0] KEY_B    = 16'hB480,
  parameter int          DEADLINE = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             in_window,
  output logic             ok,
  output logic             viol
);
  localparam int AGE_W = $clog2(DEADLINE + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(DEADLINE);

  key_state_t       state;
  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= KEY_IDLE;
      age   <= '0;
      ok    <= 1'b0;
      viol  <= 1'b0;
    end else begin
      ok   <= 1'b0;
      viol <= 1'b0;
      case (state)
        KEY_IDLE: begin
          if (key_wr) begin
            if (key_data == KEY_A[KEY_W-1:0]) begin
              state <= KEY_ARMED;
              age   <= AGE_W'(1);
            end else begin
              viol <= 1'b1;
            end
          end
        end
        KEY_ARMED: begin
          if (key_wr) begin
            state <= KEY_IDLE;
            if ((key_data == KEY_B[KEY_W-1:0]) && in_window)
              ok <= 1'b1;
            else
              viol <= 1'b1;
          end else if (age == AGE_LAST) begin
            state <= KEY_IDLE;
            viol  <= 1'b1;
          end else begin
            age <= age + 1'b1;
          end
        end
        default: state <= KEY_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_fault_seq.sv
module wdog_fault_seq
  import wdog_pkg::*;
#(
  parameter int IRQ_DELAY = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic irq_first,
  input  logic fault,
  output logic irq,
  output logic sys_rst
);
  localparam int DLY_W = (IRQ_DELAY > 1) ? $clog2(IRQ_DELAY) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(IRQ_DELAY - 1);

  fault_state_t     state;
  logic [DLY_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FLT_RUN;
      dly     <= '0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      case (state)
        FLT_RUN: begin
          if (enable && fault) begin
            if (irq_first) begin
              irq   <= 1'b1;
              dly   <= '0;
              state <= FLT_WAIT;
            end else begin
              sys_rst <= 1'b1;
              state   <= FLT_HALT;
            end
          end
        end
        FLT_WAIT: begin
          if (dly == DLY_LAST) begin
            sys_rst <= 1'b1;
            state   <= FLT_HALT;
          end else begin
            dly <= dly + 1'b1;
          end
        end
        FLT_HALT: ;
        default: state <= FLT_HALT;
      endcase
    end
  end
endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
  import wdog_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter logic [2:0]  CTRL_INIT = 3'b001,
  parameter logic [31:0] WIN_INIT  = 32'h0000_0010,
  parameter logic [31:0] TMO_INIT  = 32'h0004_C4B4,
  parameter logic [15:0] KEY_A     = 16'hA602,
  parameter logic [15:0] KEY_B     = 16'hB480,
  parameter int          DEADLINE  = 20,
  parameter int          IRQ_DELAY = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        tick,
  output logic        irq,
  output logic        sys_rst,
  output logic [15:0] refresh_word
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  win_val, tmo_val;
  logic              key_wr;
  logic [HALF_W-1:0] key_data;
  logic              in_window, timeout, ok, viol;
  logic              irq_mode;

  wdog_regs #(
    .CNT_W(CNT_W), .CTRL_INIT(CTRL_INIT), .WIN_INIT(WIN_INIT),
    .TMO_INIT(TMO_INIT), .WORD_INIT(KEY_B)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .win_val(win_val), .tmo_val(tmo_val),
    .refresh_word(refresh_word), .key_wr(key_wr), .key_data(key_data)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .enable(ctrl.enable), .windowed(ctrl.windowed),
    .tick(tick), .clear(ok), .win_val(win_val), .tmo_val(tmo_val),
    .in_window(in_window), .timeout(timeout)
  );

  wdog_key_check #(
    .KEY_W(HALF_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .DEADLINE(DEADLINE)
  ) u_keys (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
    .in_window(in_window), .ok(ok), .viol(viol)
  );

  wdog_fault_seq #(.IRQ_DELAY(IRQ_DELAY)) u_fault (
    .clk(clk), .rst(rst), .enable(ctrl.enable), .irq_first(ctrl.irq_first),
    .fault(viol || timeout), .irq(irq), .sys_rst(sys_rst)
  );

  assign irq_mode = ctrl.irq_first;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int          IRQ_DELAY = 128,
  parameter logic [15:0] WORD_INIT = 16'hB480
) (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        sys_rst,
  input logic        irq_mode,
  input logic [15:0] refresh_word
);
  localparam int GAP_W = $clog2(IRQ_DELAY + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)
      gap <= '0;
    else if (irq && !sys_rst && gap != GAP_MAX)
      gap <= gap + 1'b1;
  end

  p_refresh_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> refresh_word == WORD_INIT);

  p_irq_lead_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst) && irq) |-> gap == GAP_W'(IRQ_DELAY));

  p_irq_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !sys_rst);

  p_direct_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(sys_rst) && !irq) |-> !$past(irq_mode));

  p_rst_hold_r10: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> sys_rst);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    irq |=> irq);
endmodule

bind windowed_watchdog wdog_checker #(.IRQ_DELAY(IRQ_DELAY), .WORD_INIT(KEY_B)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .sys_rst(sys_rst),
  .irq_mode(irq_mode), .refresh_word(refresh_word)
);

// File: tb/windowed_watchdog_test.sv
module windowed_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCH_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        irq, sys_rst;
  logic [15:0] refresh_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  windowed_watchdog uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .irq(irq), .sys_rst(sys_rst), .refresh_word(refresh_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      idle(n);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] c, input logic [31:0] win, input logic [31:0] tmo);
    wr(3'd3, tmo[31:16]);
    wr(3'd4, tmo[15:0]);
    wr(3'd1, win[31:16]);
    wr(3'd2, win[15:0]);
    wr(3'd0, {13'd0, c});
  endtask

  task automatic refresh(input int gap);
    wr(3'd5, 16'hA602);
    idle(gap - 1);
    wr(3'd5, 16'hB480);
  endtask

  initial begin
    idle(WATCH_CYCLES);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int a, b;
    logic [15:0] bad_a [4];
    logic [15:0] bad_b [3];
    bad_a = '{16'h0000, 16'hB480, 16'hA603, 16'hFFFF};
    bad_b = '{16'hA602, 16'h0000, 16'hB481};

    // R1 reset state
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst, 0);
    check("R1 refresh_word", refresh_word, 32'hB480);

    // R1/R4 default window bound of 16
    for (int k = 15; k <= 16; k++) begin
      do_reset();
      wr(3'd0, 16'h0003);
      wr(3'd4, 16'd100);
      wr(3'd3, 16'd0);
      ticks(k);
      refresh(1);
      idle(3);
      check("R1 R4 default window", sys_rst, (k < 16) ? 1 : 0);
    end

    // R3 R9 timeout sweep, direct reset
    for (int t = 3; t <= 9; t++) begin
      do_reset();
      cfg(3'b001, 32'd0, t);
      ticks(t - 1);
      idle(3);
      check("R3 below timeout", sys_rst, 0);
      ticks(1);
      idle(3);
      check("R3 at timeout", sys_rst, 1);
      check("R9 no irq", irq, 0);
    end

    // R2 upper half of timeout
    do_reset();
    cfg(3'b001, 32'd0, 32'h0001_0000);
    ticks(65535);
    idle(3);
    check("R2 timeout upper half below", sys_rst, 0);
    ticks(1);
    idle(3);
    check("R2 timeout upper half reached", sys_rst, 1);

    // R8 interrupt lead, via timeout and via bad key
    for (int m = 0; m < 2; m++) begin
      do_reset();
      cfg(3'b101, 32'd0, 32'd5);
      if (m == 0) ticks(5); else wr(3'd5, 16'h1234);
      a = -1; b = -1;
      for (int c = 0; c < 400; c++) begin
        @(posedge clk); #1;
        if (irq && a < 0) begin
          a = c;
          check("R8 irq before reset", sys_rst, 0);
        end
        if (sys_rst) begin b = c; break; end
      end
      check("R8 irq to reset delay", b - a, 128);
      idle(50);
      check("R10 irq held", irq, 1);
      check("R10 reset held", sys_rst, 1);
    end

    // R4 R7 window sweep, W=4 T=10
    for (int k = 0; k < 10; k++) begin
      do_reset();
      cfg(3'b011, 32'd4, 32'd10);
      ticks(k);
      refresh(1);
      idle(3);
      check("R4 window compare", sys_rst, (k < 4) ? 1 : 0);
      if (k >= 4) begin
        ticks(9);
        idle(3);
        check("R7 count cleared", sys_rst, 0);
        ticks(1);
        idle(3);
        check("R7 timeout after clear", sys_rst, 1);
      end
    end

    // R4 window mode off accepts count 0
    do_reset();
    cfg(3'b001, 32'd4, 32'd10);
    refresh(1);
    idle(3);
    check("R4 window off", sys_rst, 0);

    // R6 deadline sweep
    for (int g = 1; g <= 22; g++) begin
      do_reset();
      cfg(3'b001, 32'd0, 32'd100);
      refresh(g);
      idle(3);
      check("R6 key gap", sys_rst, (g > 20) ? 1 : 0);
    end

    // R6 no second key at all
    do_reset();
    cfg(3'b001, 32'd0, 32'd100);
    wr(3'd5, 16'hA602);
    idle(19);
    check("R6 waiting inside deadline", sys_rst, 0);
    idle(5);
    check("R6 missing second key", sys_rst, 1);

    // R5 wrong first key
    for (int i = 0; i < 4; i++) begin
      do_reset();
      cfg(3'b001, 32'd0, 32'd100);
      wr(3'd5, bad_a[i]);
      idle(3);
      check("R5 wrong first key", sys_rst, 1);
      check("R12 refresh readback", refresh_word, bad_a[i]);
    end

    // R5 wrong second key
    for (int i = 0; i < 3; i++) begin
      do_reset();
      cfg(3'b001, 32'd0, 32'd100);
      wr(3'd5, 16'hA602);
      wr(3'd5, bad_b[i]);
      idle(3);
      check("R5 wrong second key", sys_rst, 1);
    end

    // R12 readback after valid refresh
    do_reset();
    cfg(3'b001, 32'd0, 32'd100);
    wr(3'd5, 16'hA602);
    check("R12 first key readback", refresh_word, 32'hA602);
    wr(3'd5, 16'hB480);
    check("R12 second key readback", refresh_word, 32'hB480);

    // R11 disabled: no fault, counter frozen
    do_reset();
    cfg(3'b000, 32'd0, 32'd3);
    wr(3'd5, 16'h5555);
    ticks(10);
    idle(3);
    check("R11 disabled no reset", sys_rst, 0);
    check("R11 disabled no irq", irq, 0);
    wr(3'd0, 16'h0001);
    ticks(2);
    idle(3);
    check("R11 count held while disabled", sys_rst, 0);
    ticks(1);
    idle(3);
    check("R11 counting after enable", sys_rst, 1);

    // R10 reset output held long
    idle(200);
    check("R10 sys_rst held", sys_rst, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule